// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block sequences a multicycle processor through fetch, decode, execute, memory and writeback, one state per clock. A 4-bit state register moves forward under next-state logic that reads the 6-bit opcode of the instruction being executed. Every datapath strobe comes out of a register that is loaded together with the state, so the strobes always match `state_o` and never glitch.

Two extra states handle events that redirect the program. The first saves the program counter and the second loads the program counter from a handler vector. Three events lead into them: an opcode outside the supported set reaching decode, an ALU overflow at the end of an R-type execute, and an external interrupt request seen when an instruction completes. A cause register records which event occurred. A vector register holds the handler address.

Top module: `mcfsm_ctrl`

## Requirements
- R1: A synchronous active-high reset puts `state_o` at 0 (fetch), sets `cause_o` to 0 and presents the fetch strobes, even in the middle of an instruction.
- R2: State codes are: fetch 0, decode 1, address compute 2, load 3, load writeback 4, store 5, ALU execute 6, R-type writeback 7, branch 8, jump 9, save PC 10, vector jump 11. Fetch always goes to decode. From decode, opcode 000000 goes to 6, 100011 and 101011 go to 2, 000100 goes to 8, and 000010 goes to 9.
- R3: From 2, opcode 100011 goes to 3 and 101011 goes to 5. State 3 goes to 4, and state 6 goes to 7.
- R4: States 4, 5, 7, 8 and 9 return to 0 when no event is pending. State 11 always returns to 0.
- R5: `alusrc_a` is 1 in states 2, 6 and 8, and 0 in every other state.
- R6: `pc_wr` is 1 only in states 0, 9 and 11. `pc_wr_cond` is 1 only in state 8.
- R7: The other strobes follow this table:
  - `mem_rd`: states 0 and 3.
  - `ir_wr`: state 0.
  - `iord`: states 3 and 5.
  - `mem_wr`: state 5.
  - `reg_wr`: states 4 and 7.
  - `mem_to_reg`: state 4.
  - `reg_dst`: state 7.
  - `alusrc_b` (00 register B, 01 constant four, 10 sign-extended immediate, 11 shifted immediate): 01 in state 0, 11 in state 1, 10 in state 2, otherwise 00.
  - `alu_op` (00 add, 01 subtract, 10 function field): 10 in state 6, 01 in state 8, otherwise 00.
  - `pc_src` (00 ALU result, 01 ALU output register, 10 jump target, 11 handler vector): 01 in state 8, 10 in state 9, 11 in state 11, otherwise 00.
- R8: Any other opcode reaching decode goes to state 10 with `cause_o`=0 and `vector_o`=0xC0000000.
- R9: `alu_ovf` is sampled only on the clock edge that leaves state 6. If it is set, `reg_wr` is 0 in state 7, and state 7 goes to 10 with `cause_o`=1 and `vector_o`=0xC0000020. `alu_ovf` has no effect in any other state.
- R10: `irq_req` is honoured only when leaving states 4, 5, 7, 8 or 9. It then diverts to 10 with `cause_o`=2 and `vector_o`=0xC0000040. An overflow in state 7 takes precedence over a pending interrupt. `irq_req` is ignored in every other state, including 11.
- R11: State 10 always goes to 11. The value of `pc_in` during state 10 appears on `epc_o` from state 11 onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the held instruction |
| irq_req | input | 1 | External interrupt request (level) |
| alu_ovf | input | 1 | ALU signed overflow flag |
| pc_in | input | 32 | Current program counter, captured into EPC |
| state_o | output | 4 | Current sequencer state |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write if branch condition holds |
| alusrc_a | output | 1 | ALU A operand select (0 PC, 1 register A) |
| iord | output | 1 | Memory address select (0 PC, 1 ALU output) |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ir_wr | output | 1 | Instruction register load |
| reg_wr | output | 1 | Register file write |
| mem_to_reg | output | 1 | Writeback data select (1 memory data) |
| reg_dst | output | 1 | Destination register select (1 rd field) |
| alusrc_b | output | 2 | ALU B operand select |
| alu_op | output | 2 | ALU operation class |
| pc_src | output | 2 | PC next-value select |
| cause_o | output | 2 | Recorded event cause |
| epc_o | output | 32 | Saved program counter |
| vector_o | output | 32 | Handler address for the vector jump |

## Verification
The bench sweeps all 64 opcode values from fetch and checks every state and all sixteen strobe bits on each cycle. A wrong dispatch entry would send an opcode down the wrong path or fail to flag it as undefined.

Overflow is held high through load paths to show it has no effect there. It is then raised on R-type paths to show that the write is suppressed in writeback; a design that sampled overflow in the wrong cycle would still write, or would take the exception on a load. Interrupts are held high from fetch, so a design that diverted in mid-instruction, or again from the vector-jump state, would show a wrong state sequence. Holding overflow and interrupt together checks the cause priority. A reset in mid-instruction after an exception checks that the cause is cleared.

// File: rtl/mcfsm_pkg.sv
package mcfsm_pkg;
  localparam int OPC_W   = 6;
  localparam int STATE_W = 4;
  localparam int CAUSE_W = 2;

  localparam logic [STATE_W-1:0] ST_FETCH  = 4'd0;
  localparam logic [STATE_W-1:0] ST_DECODE = 4'd1;
  localparam logic [STATE_W-1:0] ST_ADDR   = 4'd2;
  localparam logic [STATE_W-1:0] ST_LOAD   = 4'd3;
  localparam logic [STATE_W-1:0] ST_LDWB   = 4'd4;
  localparam logic [STATE_W-1:0] ST_STORE  = 4'd5;
  localparam logic [STATE_W-1:0] ST_EXEC   = 4'd6;
  localparam logic [STATE_W-1:0] ST_RWB    = 4'd7;
  localparam logic [STATE_W-1:0] ST_BRANCH = 4'd8;
  localparam logic [STATE_W-1:0] ST_JUMP   = 4'd9;
  localparam logic [STATE_W-1:0] ST_SAVEPC = 4'd10;
  localparam logic [STATE_W-1:0] ST_VECJMP = 4'd11;

  localparam logic [OPC_W-1:0] OP_RTYPE = 6'b000000;
  localparam logic [OPC_W-1:0] OP_LW    = 6'b100011;
  localparam logic [OPC_W-1:0] OP_SW    = 6'b101011;
  localparam logic [OPC_W-1:0] OP_BEQ   = 6'b000100;
  localparam logic [OPC_W-1:0] OP_J     = 6'b000010;

  localparam logic [CAUSE_W-1:0] CAUSE_UNDEF = 2'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_OVF   = 2'd1;
  localparam logic [CAUSE_W-1:0] CAUSE_IRQ   = 2'd2;

  typedef struct packed {
    logic       pc_wr;
    logic       pc_wr_cond;
    logic       alusrc_a;
    logic       iord;
    logic       mem_rd;
    logic       mem_wr;
    logic       ir_wr;
    logic       reg_wr;
    logic       mem_to_reg;
    logic       reg_dst;
    logic [1:0] alusrc_b;
    logic [1:0] alu_op;
    logic [1:0] pc_src;
  } ctrl_t;
endpackage

// File: rtl/mcfsm_next_state.sv
module mcfsm_next_state
  import mcfsm_pkg::*;
(
  input  logic [STATE_W-1:0] state,
  input  logic [OPC_W-1:0]   opcode,
  input  logic               irq_req,
  input  logic               ovf_pend,
  output logic [STATE_W-1:0] nxt,
  output logic               exc_take,
  output logic [CAUSE_W-1:0] exc_cause
);
  logic done_state;

  // instruction-completion states, where an interrupt may be honoured
  always_comb begin
    done_state = 1'b0;
    case (state)
      ST_LDWB, ST_STORE, ST_RWB, ST_BRANCH, ST_JUMP: done_state = 1'b1;
      default: done_state = 1'b0;
    endcase
  end

  always_comb begin
    nxt       = ST_FETCH;
    exc_take  = 1'b0;
    exc_cause = CAUSE_IRQ;
    case (state)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: begin
        case (opcode)
          OP_RTYPE:    nxt = ST_EXEC;
          OP_LW, OP_SW: nxt = ST_ADDR;
          OP_BEQ:      nxt = ST_BRANCH;
          OP_J:        nxt = ST_JUMP;
          default: begin
            nxt       = ST_SAVEPC;
            exc_take  = 1'b1;
            exc_cause = CAUSE_UNDEF;
          end
        endcase
      end
      ST_ADDR: begin
        if (opcode == OP_LW)      nxt = ST_LOAD;
        else if (opcode == OP_SW) nxt = ST_STORE;
        else                      nxt = ST_FETCH;
      end
      ST_LOAD:   nxt = ST_LDWB;
      ST_EXEC:   nxt = ST_RWB;
      ST_SAVEPC: nxt = ST_VECJMP;
      default:   nxt = ST_FETCH;
    endcase

    // completion-time events: overflow wins over an interrupt
    if (state == ST_RWB && ovf_pend) begin
      nxt       = ST_SAVEPC;
      exc_take  = 1'b1;
      exc_cause = CAUSE_OVF;
    end else if (done_state && irq_req) begin
      nxt       = ST_SAVEPC;
      exc_take  = 1'b1;
      exc_cause = CAUSE_IRQ;
    end
  end
endmodule

// File: rtl/mcfsm_strobe_dec.sv
module mcfsm_strobe_dec
  import mcfsm_pkg::*;
(
  input  logic [STATE_W-1:0] state,
  output ctrl_t              ctrl
);
  always_comb begin
    ctrl = '0;
    case (state)
      ST_FETCH: begin
        ctrl.mem_rd   = 1'b1;
        ctrl.ir_wr    = 1'b1;
        ctrl.pc_wr    = 1'b1;
        ctrl.alusrc_b = 2'b01;
      end
      ST_DECODE: ctrl.alusrc_b = 2'b11;
      ST_ADDR: begin
        ctrl.alusrc_a = 1'b1;
        ctrl.alusrc_b = 2'b10;
      end
      ST_LOAD: begin
        ctrl.mem_rd = 1'b1;
        ctrl.iord   = 1'b1;
      end
      ST_LDWB: begin
        ctrl.reg_wr     = 1'b1;
        ctrl.mem_to_reg = 1'b1;
      end
      ST_STORE: begin
        ctrl.mem_wr = 1'b1;
        ctrl.iord   = 1'b1;
      end
      ST_EXEC: begin
        ctrl.alusrc_a = 1'b1;
        ctrl.alu_op   = 2'b10;
      end
      ST_RWB: begin
        ctrl.reg_wr  = 1'b1;
        ctrl.reg_dst = 1'b1;
      end
      ST_BRANCH: begin
        ctrl.alusrc_a   = 1'b1;
        ctrl.alu_op     = 2'b01;
        ctrl.pc_wr_cond = 1'b1;
        ctrl.pc_src     = 2'b01;
      end
      ST_JUMP: begin
        ctrl.pc_wr  = 1'b1;
        ctrl.pc_src = 2'b10;
      end
      ST_VECJMP: begin
        ctrl.pc_wr  = 1'b1;
        ctrl.pc_src = 2'b11;
      end
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/mcfsm_vector_sel.sv
module mcfsm_vector_sel
  import mcfsm_pkg::*;
#(
  parameter int                XLEN      = 32,
  parameter logic [XLEN-1:0]   UNDEF_VEC = 32'hC000_0000,
  parameter logic [XLEN-1:0]   OVF_VEC   = 32'hC000_0020,
  parameter logic [XLEN-1:0]   IRQ_VEC   = 32'hC000_0040
) (
  input  logic [CAUSE_W-1:0] cause,
  output logic [XLEN-1:0]    vector
);
  always_comb begin
    case (cause)
      CAUSE_UNDEF: vector = UNDEF_VEC;
      CAUSE_OVF:   vector = OVF_VEC;
      default:     vector = IRQ_VEC;
    endcase
  end
endmodule

// File: rtl/mcfsm_ctrl.sv
module mcfsm_ctrl
  import mcfsm_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter logic [XLEN-1:0] UNDEF_VEC = 32'hC000_0000,
  parameter logic [XLEN-1:0] OVF_VEC   = 32'hC000_0020,
  parameter logic [XLEN-1:0] IRQ_VEC   = 32'hC000_0040
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [OPC_W-1:0]   opcode,
  input  logic               irq_req,
  input  logic               alu_ovf,
  input  logic [XLEN-1:0]    pc_in,
  output logic [STATE_W-1:0] state_o,
  output logic               pc_wr,
  output logic               pc_wr_cond,
  output logic               alusrc_a,
  output logic               iord,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic               ir_wr,
  output logic               reg_wr,
  output logic               mem_to_reg,
  output logic               reg_dst,
  output logic [1:0]         alusrc_b,
  output logic [1:0]         alu_op,
  output logic [1:0]         pc_src,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [XLEN-1:0]    epc_o,
  output logic [XLEN-1:0]    vector_o
);
  logic [STATE_W-1:0] state_q, nxt, dec_in;
  logic               ovf_q, exc_take;
  logic [CAUSE_W-1:0] exc_cause, cause_q;
  logic [XLEN-1:0]    epc_q, vector_q, vec_n;
  ctrl_t              dec_ctrl, ctrl_n, ctrl_q;

  mcfsm_next_state u_next (
    .state     (state_q),
    .opcode    (opcode),
    .irq_req   (irq_req),
    .ovf_pend  (ovf_q),
    .nxt       (nxt),
    .exc_take  (exc_take),
    .exc_cause (exc_cause)
  );

  // decode the state about to be entered, so strobes register alongside it
  assign dec_in = rst ? ST_FETCH : nxt;

  mcfsm_strobe_dec u_dec (
    .state (dec_in),
    .ctrl  (dec_ctrl)
  );

  mcfsm_vector_sel #(
    .XLEN      (XLEN),
    .UNDEF_VEC (UNDEF_VEC),
    .OVF_VEC   (OVF_VEC),
    .IRQ_VEC   (IRQ_VEC)
  ) u_vec (
    .cause  (exc_cause),
    .vector (vec_n)
  );

  // writeback of an overflowing result is dropped on entry to state 7
  always_comb begin
    ctrl_n = dec_ctrl;
    if (!rst && state_q == ST_EXEC && alu_ovf) ctrl_n.reg_wr = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_FETCH;
      ctrl_q   <= ctrl_n;
      ovf_q    <= 1'b0;
      cause_q  <= CAUSE_UNDEF;
      vector_q <= UNDEF_VEC;
      epc_q    <= '0;
    end else begin
      state_q <= nxt;
      ctrl_q  <= ctrl_n;
      ovf_q   <= (state_q == ST_EXEC) && alu_ovf;
      if (exc_take) begin
        cause_q  <= exc_cause;
        vector_q <= vec_n;
      end
      if (state_q == ST_SAVEPC) epc_q <= pc_in;
    end
  end

  assign state_o    = state_q;
  assign pc_wr      = ctrl_q.pc_wr;
  assign pc_wr_cond = ctrl_q.pc_wr_cond;
  assign alusrc_a   = ctrl_q.alusrc_a;
  assign iord       = ctrl_q.iord;
  assign mem_rd     = ctrl_q.mem_rd;
  assign mem_wr     = ctrl_q.mem_wr;
  assign ir_wr      = ctrl_q.ir_wr;
  assign reg_wr     = ctrl_q.reg_wr;
  assign mem_to_reg = ctrl_q.mem_to_reg;
  assign reg_dst    = ctrl_q.reg_dst;
  assign alusrc_b   = ctrl_q.alusrc_b;
  assign alu_op     = ctrl_q.alu_op;
  assign pc_src     = ctrl_q.pc_src;
  assign cause_o    = cause_q;
  assign epc_o      = epc_q;
  assign vector_o   = vector_q;

  assert_fetch_to_decode_R2: assert property (@(posedge clk) disable iff (rst)
    state_q == ST_FETCH |=> state_q == ST_DECODE);

  assert_pcwrite_states_R6: assert property (@(posedge clk) disable iff (rst)
    pc_wr |-> (state_q == ST_FETCH || state_q == ST_JUMP || state_q == ST_VECJMP));

  assert_cond_write_branch_R6: assert property (@(posedge clk) disable iff (rst)
    pc_wr_cond |-> state_q == ST_BRANCH);

  assert_alusrca_states_R5: assert property (@(posedge clk) disable iff (rst)
    alusrc_a |-> (state_q == ST_ADDR || state_q == ST_EXEC || state_q == ST_BRANCH));

  assert_mem_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  assert_no_ovf_write_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RWB && ovf_q) |-> !reg_wr);

  assert_irq_midway_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FETCH || state_q == ST_ADDR || state_q == ST_LOAD ||
     state_q == ST_EXEC || state_q == ST_VECJMP) |=> state_q != ST_SAVEPC);

  assert_save_then_vector_R11: assert property (@(posedge clk) disable iff (rst)
    state_q == ST_SAVEPC |=> (state_q == ST_VECJMP && epc_o == $past(pc_in)));

  assert_illegal_recovers: assert property (@(posedge clk) disable iff (rst)
    state_q > ST_VECJMP |=> state_q == ST_FETCH);
endmodule

// File: tb/mcfsm_ctrl_test.sv
`timescale 1ns/1ps
module mcfsm_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  opcode = '0;
  logic        irq_req = 1'b0;
  logic        alu_ovf = 1'b0;
  logic [31:0] pc_in = 32'h0040_0000;
  logic [3:0]  state_o;
  logic        pc_wr, pc_wr_cond, alusrc_a, iord, mem_rd, mem_wr, ir_wr;
  logic        reg_wr, mem_to_reg, reg_dst;
  logic [1:0]  alusrc_b, alu_op, pc_src, cause_o;
  logic [31:0] epc_o, vector_o;
  logic [15:0] got;

  int tests = 0;
  int fails = 0;
  int tick  = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  mcfsm_ctrl uut (
    .clk(clk), .rst(rst), .opcode(opcode), .irq_req(irq_req), .alu_ovf(alu_ovf),
    .pc_in(pc_in), .state_o(state_o), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond),
    .alusrc_a(alusrc_a), .iord(iord), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .ir_wr(ir_wr), .reg_wr(reg_wr), .mem_to_reg(mem_to_reg), .reg_dst(reg_dst),
    .alusrc_b(alusrc_b), .alu_op(alu_op), .pc_src(pc_src), .cause_o(cause_o),
    .epc_o(epc_o), .vector_o(vector_o)
  );

  assign got = {pc_wr, pc_wr_cond, alusrc_a, iord, mem_rd, mem_wr, ir_wr, reg_wr,
                mem_to_reg, reg_dst, alusrc_b, alu_op, pc_src};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (state %0d)", req, act, exp, state_o);
    end
  endtask

  // strobe word per state, field order as in 'got' (R5, R6, R7)
  function automatic logic [15:0] exp_ctrl(input int s, input bit ovf);
    case (s)
      0:  return 16'b1000_1010_0001_0000;
      1:  return 16'b0000_0000_0011_0000;
      2:  return 16'b0010_0000_0010_0000;
      3:  return 16'b0001_1000_0000_0000;
      4:  return 16'b0000_0001_1000_0000;
      5:  return 16'b0001_0100_0000_0000;
      6:  return 16'b0010_0000_0000_1000;
      7:  return {7'b0000_000, ~ovf, 8'b0100_0000};
      8:  return 16'b0110_0000_0000_0101;
      9:  return 16'b1000_0000_0000_0010;
      11: return 16'b1000_0000_0000_0011;
      default: return 16'h0000;
    endcase
  endfunction

  // expected successor (R2, R3, R4, R8, R9, R10, R11)
  function automatic int exp_next(input int s, input logic [5:0] op, input bit irq, input bit ovf);
    case (s)
      0: return 1;
      1: begin
        if (op == 6'b000000) return 6;
        if (op == 6'b100011 || op == 6'b101011) return 2;
        if (op == 6'b000100) return 8;
        if (op == 6'b000010) return 9;
        return 10;
      end
      2: return (op == 6'b100011) ? 3 : 5;
      3: return 4;
      6: return 7;
      7: return (ovf || irq) ? 10 : 0;
      4, 5, 8, 9: return irq ? 10 : 0;
      10: return 11;
      default: return 0;
    endcase
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    tick++;
    pc_in = 32'h0040_0000 + tick * 4;
  endtask

  task automatic run_instr(input logic [5:0] op, input bit irq, input bit ovf);
    int s = 0;
    int prev;
    bit ovf_l = 0;
    logic [31:0] epc_exp = '0;
    logic [31:0] vec_exp;
    int cause_exp;
    opcode  = op;
    irq_req = irq;
    alu_ovf = ovf;
    for (int k = 0; k < 10; k++) begin
      prev = s;
      if (prev == 10) epc_exp = pc_in;
      step();
      s = exp_next(prev, op, irq, ovf_l);
      if (prev == 6) ovf_l = ovf;
      check("R2/R3/R4 state sequence", {28'd0, state_o}, s);
      check("R5/R6/R7/R9 strobes", {16'd0, got}, {16'd0, exp_ctrl(s, ovf_l)});
      if (s == 10) begin
        cause_exp = (prev == 1) ? 0 : ((prev == 7 && ovf_l) ? 1 : 2);
        vec_exp   = 32'hC000_0000 + cause_exp * 32'h20;
        check("R8/R9/R10 cause", {30'd0, cause_o}, cause_exp);
        check("R8/R9/R10 vector", vector_o, vec_exp);
      end
      if (s == 11) check("R11 saved pc", epc_o, epc_exp);
      if (s == 0) break;
    end
    irq_req = 1'b0;
    alu_ovf = 1'b0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1 reset state", {28'd0, state_o}, 0);
    check("R1 reset strobes", {16'd0, got}, {16'd0, exp_ctrl(0, 0)});
    check("R1 reset cause", {30'd0, cause_o}, 0);
    rst = 1'b0;

    // R2 R8: sweep every opcode, no events
    for (int op = 0; op < 64; op++) run_instr(op[5:0], 1'b0, 1'b0);

    // R9: overflow ignored outside ALU execute, then taken on R-type
    run_instr(6'b100011, 1'b0, 1'b1);
    run_instr(6'b101011, 1'b0, 1'b1);
    run_instr(6'b000000, 1'b0, 1'b1);

    // R10: interrupt held from fetch, diverts only at completion
    run_instr(6'b100011, 1'b1, 1'b0);
    run_instr(6'b101011, 1'b1, 1'b0);
    run_instr(6'b000100, 1'b1, 1'b0);
    run_instr(6'b000010, 1'b1, 1'b0);
    run_instr(6'b000000, 1'b1, 1'b0);
    run_instr(6'b000000, 1'b1, 1'b1);   // overflow takes precedence
    run_instr(6'b111111, 1'b1, 1'b0);   // undefined wins at decode
    run_instr(6'b000000, 1'b0, 1'b1);   // leaves cause at 1

    // R1: reset in mid-instruction clears the state and the cause
    opcode = 6'b000000;
    step();
    step();
    check("R1 mid-run reach exec", {28'd0, state_o}, 6);
    rst = 1'b1;
    step();
    check("R1 mid-run reset state", {28'd0, state_o}, 0);
    check("R1 mid-run reset cause", {30'd0, cause_o}, 0);
    check("R1 mid-run reset strobes", {16'd0, got}, {16'd0, exp_ctrl(0, 0)});
    rst = 1'b0;
    run_instr(6'b000100, 1'b0, 1'b0);

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule